// File: doc/BRIEF.md
# Fractional Ratio Divider with Carry-Driven Modulus Control

This block divides a fast oscillator clock by a ratio whose long-run average is fractional. Each output cycle is either N or N+1 oscillator cycles long. The choice for each cycle comes from the carry of an m-bit phase accumulator. That accumulator advances once per output cycle by the fraction word x. Over any run of 2^m output cycles the carry is high exactly x times, so the average ratio is N + x/2^m.

The accumulator contents are brought out as a phase code with 2^m equal steps, for use by a downstream delay-tap selector. The carry that sets the length of the cycle in progress is also brought out.

N and x are written through a load strobe into shadow registers. They are only used at an output-cycle boundary, so an output cycle never has a length outside the old or the new ratio range.

The control is a three-state machine:
- **IDLE** is entered at reset and produces no pulses. It moves to COUNT on the first load.
- **COUNT** counts down the remaining oscillator cycles. It stays in COUNT while more than one cycle remains, and moves to TERM when one remains.
- **TERM** is the terminal cycle. It emits the output pulse, steps the accumulator, reloads the counter and always returns to COUNT.

Top module: `frac_div_top`

## Requirements
- R1: After reset, div_pulse, carry and phase_code are 0. No pulse appears until the first load strobe.
- R2: The first output cycle after the first load has phase_code 0 and carry 0 when its pulse appears.
- R3: At each pulse the accumulator adds x modulo 2^m. The phase_code seen at the next pulse is (previous phase_code + x) mod 2^m. The carry seen at that pulse is 1 exactly when that addition overflowed.
- R4: The spacing between consecutive pulses, in oscillator cycles, is N + carry. Here carry is the value present during that output cycle, which is also the value shown at the pulse that ends it.
- R5: Over any 2^m consecutive output cycles with fixed N and x, the total length is N·2^m + x oscillator cycles.
- R6: With m = 3 and x = 2, the phase_code at successive pulses runs 0, 2, 4, 6 and repeats. The carry is low for three pulses and high on the fourth.
- R7: With x = 0, every output cycle is N long and the carry never asserts.
- R8: A load strobe is sampled on a clock edge. The new values are used only from the first cycle boundary strictly after that edge. A strobe that lands on the terminal cycle leaves the cycle that starts there on the old N and x.
- R9: div_pulse is high for exactly one oscillator cycle per output cycle.
- R10: An N value below 2 is treated as 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| ratio_int | input | INT_W | Integer ratio N |
| ratio_frac | input | FRAC_W | Fraction word x (fraction x/2^m) |
| load | input | 1 | Strobe that captures ratio_int and ratio_frac |
| div_pulse | output | 1 | One-cycle pulse at the end of each output cycle |
| carry | output | 1 | High when the output cycle in progress is N+1 long |
| phase_code | output | FRAC_W | Accumulator contents for the cycle in progress |

## Verification
Two functions can fall in the same clock cycle: a load strobe arriving, and the terminal-count boundary that samples the shadow values. The bench provokes this by raising the strobe at the falling edge inside the TERM cycle, so that the strobe and the boundary are both sampled on the same rising edge. It then judges the two following output cycles: the first must keep the old ratio and the old phase step, and the second must use the new ones. Mid-cycle strobes and constrained-random N and x windows cover the rest.

// File: rtl/fdiv_pkg.sv
package fdiv_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_COUNT = 2'd1,
        ST_TERM  = 2'd2
    } div_state_t;

    localparam int MIN_RATIO = 2;

endpackage

// File: rtl/fd_ratio_shadow.sv
module fd_ratio_shadow #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [INT_W-1:0]  int_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [INT_W-1:0]  int_live_o,
    output logic [INT_W-1:0]  int_q_o,
    output logic [FRAC_W-1:0] frac_q_o
);
    import fdiv_pkg::*;

    localparam logic [INT_W-1:0] FLOOR = INT_W'(MIN_RATIO);

    logic [INT_W-1:0] int_clamped;

    // R10: ratios below the floor are raised to it before use
    always_comb begin
        int_clamped = (int_i < FLOOR) ? FLOOR : int_i;
    end

    assign int_live_o = int_clamped;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            int_q_o  <= FLOOR;
            frac_q_o <= '0;
        end else if (load_i) begin
            int_q_o  <= int_clamped;
            frac_q_o <= frac_i;
        end
    end

    assert_floor_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        int_q_o >= FLOOR);

    assert_hold_without_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !load_i |=> $stable(int_q_o) && $stable(frac_q_o));

endmodule

// File: rtl/fd_phase_accum.sv
module fd_phase_accum #(
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              step_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic [FRAC_W-1:0] acc_o,
    output logic              carry_o,
    output logic              carry_nxt_o
);
    logic [FRAC_W:0] sum;

    always_comb begin
        sum = {1'b0, acc_o} + {1'b0, frac_i};
    end

    assign carry_nxt_o = sum[FRAC_W];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            acc_o   <= '0;
            carry_o <= 1'b0;
        end else if (clear_i) begin
            acc_o   <= '0;
            carry_o <= 1'b0;
        end else if (step_i) begin
            acc_o   <= sum[FRAC_W-1:0];
            carry_o <= sum[FRAC_W];
        end
    end

    // R3: an overflowing step wraps the contents below their prior value
    assert_wrap_drops_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !clear_i && carry_nxt_o |=> acc_o < $past(acc_o));

    // R3: a step without overflow never moves the contents down
    assert_no_wrap_rises_R3: assert property (@(posedge clk) disable iff (!rst_n)
        step_i && !clear_i && !carry_nxt_o |=> acc_o >= $past(acc_o));

    // R4: between boundaries the carry and phase stay put
    assert_still_between_steps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !step_i && !clear_i |=> $stable(acc_o) && $stable(carry_o));

endmodule

// File: rtl/fd_cycle_fsm.sv
module fd_cycle_fsm #(
    parameter int INT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [INT_W-1:0] start_int_i,
    input  logic [INT_W-1:0] shadow_int_i,
    input  logic             carry_nxt_i,
    output logic             pulse_o,
    output logic             start_o,
    output logic             step_o
);
    import fdiv_pkg::*;

    localparam int CNT_W = INT_W + 1;
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    div_state_t       state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] ratio_next;

    always_comb begin
        ratio_next = {1'b0, shadow_int_i} + CNT_W'(carry_nxt_i);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (load_i) state_d = ST_COUNT;
            ST_COUNT: if (cnt_q == ONE) state_d = ST_TERM;
            ST_TERM:  state_d = ST_COUNT;
            default:  state_d = ST_IDLE;
        endcase
    end

    // down-counter of remaining oscillator cycles
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE:  if (load_i) cnt_q <= {1'b0, start_int_i} - ONE;
                ST_COUNT: cnt_q <= cnt_q - ONE;
                ST_TERM:  cnt_q <= ratio_next - ONE;
                default:  cnt_q <= '0;
            endcase
        end
    end

    // outputs
    always_comb begin
        pulse_o = 1'b0;
        start_o = 1'b0;
        step_o  = 1'b0;
        unique case (state_q)
            ST_IDLE:  start_o = load_i;
            ST_COUNT: ;
            ST_TERM:  begin pulse_o = 1'b1; step_o = 1'b1; end
            default:  ;
        endcase
    end

    // R10: a reload never leaves a zero count behind
    assert_reload_nonzero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (step_o || start_o) |=> cnt_q >= ONE);

    // R9: a terminal cycle is always followed by counting
    assert_term_then_count_R9: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_TERM |=> state_q == ST_COUNT);

    // R1: no pulse while waiting for the first load
    assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        state_q == ST_IDLE && !load_i |=> state_q == ST_IDLE && !pulse_o);

endmodule

// File: rtl/frac_div_top.sv
module frac_div_top #(
    parameter int INT_W  = 8,
    parameter int FRAC_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [INT_W-1:0]  ratio_int,
    input  logic [FRAC_W-1:0] ratio_frac,
    input  logic              load,
    output logic              div_pulse,
    output logic              carry,
    output logic [FRAC_W-1:0] phase_code
);
    logic [INT_W-1:0]  int_live;
    logic [INT_W-1:0]  int_q;
    logic [FRAC_W-1:0] frac_q;
    logic              carry_nxt;
    logic              start;
    logic              step;

    fd_ratio_shadow #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_shadow (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (load),
        .int_i      (ratio_int),
        .frac_i     (ratio_frac),
        .int_live_o (int_live),
        .int_q_o    (int_q),
        .frac_q_o   (frac_q)
    );

    fd_phase_accum #(.FRAC_W(FRAC_W)) u_accum (
        .clk         (clk),
        .rst_n       (rst_n),
        .clear_i     (start),
        .step_i      (step),
        .frac_i      (frac_q),
        .acc_o       (phase_code),
        .carry_o     (carry),
        .carry_nxt_o (carry_nxt)
    );

    fd_cycle_fsm #(.INT_W(INT_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .load_i       (load),
        .start_int_i  (int_live),
        .shadow_int_i (int_q),
        .carry_nxt_i  (carry_nxt),
        .pulse_o      (div_pulse),
        .start_o      (start),
        .step_o       (step)
    );

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse |=> !div_pulse);

    assert_zero_frac_no_carry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        div_pulse && frac_q == '0 |=> !carry);

    assert_first_cycle_clean_R2: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> phase_code == '0 && !carry);

endmodule

// File: tb/test_frac_div_top.sv
module test_frac_div_top;
    localparam int INT_W  = 8;
    localparam int FRAC_W = 3;
    localparam int MOD    = 1 << FRAC_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              load = 1'b0;
    logic [INT_W-1:0]  n_in = '0;
    logic [FRAC_W-1:0] x_in = '0;
    logic              div_pulse;
    logic              carry;
    logic [FRAC_W-1:0] phase_code;

    frac_div_top #(.INT_W(INT_W), .FRAC_W(FRAC_W)) i_frac_div_top (
        .clk        (clk),
        .rst_n      (rst_n),
        .ratio_int  (n_in),
        .ratio_frac (x_in),
        .load       (load),
        .div_pulse  (div_pulse),
        .carry      (carry),
        .phase_code (phase_code)
    );

    always #5 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc++;

    int vectors = 0;
    int errors  = 0;
    int last_pulse = -1;
    bit done = 1'b0;

    function automatic int eff(int n);
        return (n < 2) ? 2 : n;
    endfunction

    function automatic int step_phase(int ph, int x);
        return (ph + x) % MOD;
    endfunction

    function automatic int step_carry(int ph, int x);
        return ((ph + x) >= MOD) ? 1 : 0;
    endfunction

    task automatic chk(bit ok, string req, int act, int exp);
        vectors++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_pulse(output int per, output int ph, output int cy);
        int guard = 0;
        do begin
            @(negedge clk);
            guard++;
        end while (!div_pulse && guard < 2000);
        if (!div_pulse) chk(1'b0, "R4 pulse missing", 0, 1);
        per = (last_pulse < 0) ? -1 : cyc - last_pulse;
        last_pulse = cyc;
        ph = phase_code;
        cy = carry;
    endtask

    task automatic do_load(int n, int x);
        @(negedge clk);
        n_in = INT_W'(n);
        x_in = FRAC_W'(x);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
    endtask

    // settle past the boundary, then check 2^m cycles
    task automatic run_window(int n, int x, string ptag);
        int per, ph, cy, prev, total, ncar;
        wait_pulse(per, ph, cy);
        wait_pulse(per, ph, cy);
        prev = ph;
        total = 0;
        ncar = 0;
        for (int i = 0; i < MOD; i++) begin
            wait_pulse(per, ph, cy);
            chk(ph == step_phase(prev, x), "R3 phase", ph, step_phase(prev, x));
            chk(cy == step_carry(prev, x), "R3 carry", cy, step_carry(prev, x));
            chk(per == eff(n) + cy, ptag, per, eff(n) + cy);
            total += per;
            ncar += cy;
            prev = ph;
        end
        chk(total == eff(n) * MOD + x, "R5 window total", total, eff(n) * MOD + x);
        if (x == 0) chk(ncar == 0, "R7 carry count", ncar, 0);
    endtask

    initial begin
        #(150000 * 10);
        if (!done) begin
            errors++;
            vectors++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cyc, 0);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        int per, ph, cy, prev, quiet, old_n, p0;
        void'($urandom(32'd20240611));

        // R1: reset state
        repeat (3) @(negedge clk);
        chk(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
        chk(carry == 1'b0, "R1 carry in reset", carry, 0);
        chk(phase_code == '0, "R1 phase in reset", phase_code, 0);
        rst_n = 1'b1;
        quiet = 0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (div_pulse) quiet++;
        end
        chk(quiet == 0, "R1 pulses before load", quiet, 0);

        // R2 and R6: N=4, x=2
        do_load(4, 2);
        last_pulse = -1;
        wait_pulse(per, ph, cy);
        chk(ph == 0, "R2 first phase", ph, 0);
        chk(cy == 0, "R2 first carry", cy, 0);
        @(negedge clk);
        chk(div_pulse == 1'b0, "R9 pulse width", div_pulse, 0);
        p0 = 0;
        for (int k = 1; k <= 8; k++) begin
            wait_pulse(per, ph, cy);
            chk(ph == (2 * k) % MOD, "R6 phase", ph, (2 * k) % MOD);
            chk(cy == ((k % 4) == 0 ? 1 : 0), "R6 carry", cy, (k % 4) == 0 ? 1 : 0);
            chk(per == 4 + cy, "R4 period", per, 4 + cy);
            p0 += per;
        end
        chk(p0 == 34, "R5 window x=2", p0, 34);

        // R7: integer mode
        do_load(5, 0);
        run_window(5, 0, "R7 period");

        // R10: ratios below the floor
        do_load(0, 0);
        run_window(0, 0, "R10 period N=0");
        do_load(1, 3);
        run_window(1, 3, "R10 period N=1");

        // extremes
        do_load(255, 7);
        run_window(255, 7, "R4 period max");
        do_load(2, 1);
        run_window(2, 1, "R4 period min");

        // R8: strobe coinciding with the terminal cycle
        do_load(6, 1);
        run_window(6, 1, "R4 period");
        wait_pulse(per, ph, cy);
        prev = ph;
        n_in = INT_W'(9);
        x_in = FRAC_W'(5);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_pulse(per, ph, cy);
        chk(ph == step_phase(prev, 1), "R8 old step kept", ph, step_phase(prev, 1));
        chk(per == 6 + cy, "R8 old ratio kept", per, 6 + cy);
        prev = ph;
        wait_pulse(per, ph, cy);
        chk(ph == step_phase(prev, 5), "R8 new step used", ph, step_phase(prev, 5));
        chk(per == 9 + cy, "R8 new ratio used", per, 9 + cy);

        // R8: strobe in the middle of a cycle
        old_n = 9;
        wait_pulse(per, ph, cy);
        repeat (2) @(negedge clk);
        n_in = INT_W'(3);
        x_in = FRAC_W'(4);
        load = 1'b1;
        @(negedge clk);
        load = 1'b0;
        wait_pulse(per, ph, cy);
        chk(per == old_n + cy, "R8 mid-cycle old ratio", per, old_n + cy);
        wait_pulse(per, ph, cy);
        chk(per == 3 + cy, "R8 mid-cycle new ratio", per, 3 + cy);

        // constrained random windows
        for (int r = 0; r < 14; r++) begin
            int n, x;
            n = ($urandom_range(0, 5) == 0) ? int'($urandom_range(0, 1))
                                            : int'($urandom_range(2, 40));
            x = int'($urandom_range(0, MOD - 1));
            do_load(n, x);
            run_window(n, x, "R4 period random");
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end

endmodule